// File: doc/BRIEF.md
# Up/Down Timer with Compare Flag

This block is an 8-bit programmable timer/counter with one compare channel. A clock-select and prescaler stage outside the block supplies a one-cycle tick enable. The counter moves only on cycles where that enable is high and the 3-bit clock select code is non-zero. A 2-bit waveform mode picks how the count moves on each tick: plain wrap-around counting, counting that clears on compare match, or up/down counting. The mode also picks the tick on which the overflow flag is raised.

An equality comparator watches the count against a compare register at all times. A match raises the compare flag on the following tick, not on the cycle where equality first appears. Both flags are cleared either by writing a one to their bit in the flag register or by their own acknowledge strobe. A compare interrupt request leaves the block when the compare flag, the channel enable and the global enable are all high. A simple CPU register port reads and writes the count, the compare value and the flags. A CPU write to the count always wins over the timer's own stepping.

Top module: `updown_timer`

## Requirements
- R1: After reset the count, the compare register and both flags are zero, `cmp_irq` is low, `at_bottom` is high and `at_top` is low.
- R2: A tick happens only on a cycle where `tick_en` is high and `clk_sel` is non-zero. On any other cycle the count holds. Even with `clk_sel` at 000, the CPU can still read and write the count.
- R3: In mode 00 each tick adds one, and 255 wraps to 0. The overflow flag sets on the tick taken while the count is 255.
- R4: In mode 10 a tick taken while the count equals the compare register loads 0. Any other tick adds one.
- R5: In mode 01 the count climbs to 255, turns and descends to 0, then turns and climbs again, so the sequence runs ..., 254, 255, 254, ..., 1, 0, 1, .... The overflow flag sets on the tick taken while the count is 0.
- R6: In mode 11 each tick adds one with wrap. The overflow flag sets on the tick taken while the count is 254, so it becomes visible together with a count of 255.
- R7: A CPU write to address 0 loads the count on the next edge and overrides any tick in that cycle. A write to address 1 loads the compare register. Reads return the count at address 0, the compare value at 1, and the flags at 2.
- R8: `at_top` is high exactly when the count is 255, and `at_bottom` is high exactly when the count is 0.
- R9: `cmp_match` is high while the count equals the compare register. The compare flag sets only on a tick taken while `cmp_match` is high, and it becomes visible the cycle after that tick.
- R10: Address 2 holds the overflow flag in bit 0 and the compare flag in bit 1. Writing a one to a bit clears that flag, and writing a zero leaves it unchanged. A set in the same cycle beats a clear.
- R11: `ovf_ack` clears the overflow flag and `cmp_ack` clears the compare flag.
- R12: `cmp_irq` is high exactly when the compare flag, `cmp_ie` and `glob_ie` are all high.
- R13: After a CPU write to the count, the first tick that follows cannot set the compare flag, even if the written value equals the compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick enable from the prescaler stage |
| clk_sel | input | 3 | Clock select code; 000 stops the timer |
| wave_mode | input | 2 | Counting and overflow mode |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 2 | Register address: 0 count, 1 compare, 2 flags |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for `cpu_addr` |
| cmp_ie | input | 1 | Compare interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| ovf_ack | input | 1 | Overflow interrupt acknowledge strobe |
| cmp_ack | input | 1 | Compare interrupt acknowledge strobe |
| count_o | output | 8 | Current count |
| at_top | output | 1 | Count at maximum |
| at_bottom | output | 1 | Count at zero |
| cmp_match | output | 1 | Count equals compare register |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
Two corner cases are hard to reach from the ports. One is a flag clear that lands on the exact tick where the flag is being set. The other is a count write that lands on a value equal to the compare register, so that a suppressed match can be told apart from a real one. The stimulus holds `tick_en` low while it loads the count and compare registers. It then releases single ticks one at a time, so the edge where equality is first acted on is known exactly. For the same-cycle case it raises the tick and the write-one clear on the same negative clock edge.

// File: rtl/updown_timer_pkg.sv
package updown_timer_pkg;

  typedef enum logic [1:0] {
    MODE_WRAP      = 2'b00,
    MODE_UPDN      = 2'b01,
    MODE_CTC       = 2'b10,
    MODE_WRAP_TOPF = 2'b11
  } wave_mode_e;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd2;

  localparam int FLAG_OVF_BIT = 0;
  localparam int FLAG_CMP_BIT = 1;

endpackage

// File: rtl/utmr_counter.sv
module utmr_counter
  import updown_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  input  wave_mode_e       mode,
  input  logic             match,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt,
  output logic             at_top,
  output logic             at_bottom
);

  localparam logic [CNT_W-1:0] MAX_VAL  = '1;
  localparam logic [CNT_W-1:0] ZERO_VAL = '0;
  localparam logic [CNT_W-1:0] ONE_VAL  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             dir_up_q;
  logic [CNT_W-1:0] nxt_cnt;
  logic             nxt_dir;
  logic             step_now;

  // Direction to use on this tick; only mode 01 ever turns downward.
  function automatic logic step_dir(input wave_mode_e m, input logic [CNT_W-1:0] c,
                                    input logic up);
    if (m != MODE_UPDN) return 1'b1;
    if (c == MAX_VAL)   return 1'b0;
    if (c == ZERO_VAL)  return 1'b1;
    return up;
  endfunction

  function automatic logic [CNT_W-1:0] step_count(input wave_mode_e m,
                                                  input logic [CNT_W-1:0] c,
                                                  input logic up, input logic eq);
    case (m)
      MODE_CTC:  return eq ? ZERO_VAL : c + ONE_VAL;
      MODE_UPDN: return up ? c + ONE_VAL : c - ONE_VAL;
      default:   return c + ONE_VAL;
    endcase
  endfunction

  // Count value on which a tick raises the overflow flag, per mode.
  function automatic logic ovf_hit(input wave_mode_e m, input logic [CNT_W-1:0] c);
    case (m)
      MODE_UPDN:      return c == ZERO_VAL;
      MODE_WRAP_TOPF: return c == MAX_VAL - ONE_VAL;
      default:        return c == MAX_VAL;
    endcase
  endfunction

  assign nxt_dir  = step_dir(mode, cnt_q, dir_up_q);
  assign nxt_cnt  = step_count(mode, cnt_q, nxt_dir, match);
  assign step_now = tick && !wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= ZERO_VAL;
      dir_up_q <= 1'b1;
    end else if (wr_cnt) begin
      cnt_q <= wdata;
    end else if (tick) begin
      cnt_q    <= nxt_cnt;
      dir_up_q <= nxt_dir;
    end
  end

  assign count     = cnt_q;
  assign ovf_evt   = step_now && ovf_hit(mode, cnt_q);
  assign at_top    = (cnt_q == MAX_VAL);
  assign at_bottom = (cnt_q == ZERO_VAL);

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(count)); // R2

  AST_CPU_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (count == $past(wdata))); // R7

  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_now && mode == MODE_WRAP) |=> (count == $past(count) + ONE_VAL)); // R3

  AST_UPDN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_now && mode == MODE_UPDN && at_top) |=> (count == MAX_VAL - ONE_VAL)); // R5

endmodule

// File: rtl/utmr_compare.sv
module utmr_compare #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmp_val,
  output logic             match,
  output logic             cmp_set
);

  logic [CNT_W-1:0] cmp_q;
  logic             block_q;

  function automatic logic equal_now(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return a == b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (wr_cmp) begin
      cmp_q <= wdata;
    end
  end

  // A count write arms the block; the next tick consumes it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      block_q <= 1'b0;
    end else if (wr_cnt) begin
      block_q <= 1'b1;
    end else if (tick) begin
      block_q <= 1'b0;
    end
  end

  assign cmp_val = cmp_q;
  assign match   = equal_now(count, cmp_q);
  assign cmp_set = tick && match && !block_q;

  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> !cmp_set); // R13

endmodule

// File: rtl/utmr_flags.sv
module utmr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_set,
  input  logic cmp_set,
  input  logic wr_flags,
  input  logic wr_ovf_bit,
  input  logic wr_cmp_bit,
  input  logic ovf_ack,
  input  logic cmp_ack,
  input  logic cmp_ie,
  input  logic glob_ie,
  output logic ovf_flag,
  output logic cmp_flag,
  output logic cmp_irq
);

  logic ovf_q;
  logic cmp_q;
  logic ovf_clr;
  logic cmp_clr;

  assign ovf_clr = (wr_flags && wr_ovf_bit) || ovf_ack;
  assign cmp_clr = (wr_flags && wr_cmp_bit) || cmp_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      if (cmp_set)      cmp_q <= 1'b1;
      else if (cmp_clr) cmp_q <= 1'b0;
    end
  end

  assign ovf_flag = ovf_q;
  assign cmp_flag = cmp_q;
  assign cmp_irq  = cmp_q && cmp_ie && glob_ie;

  AST_CMP_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> $past(cmp_set)); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ack && !cmp_set) |=> !cmp_flag); // R11

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && ovf_clr) |=> ovf_flag); // R10

endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import updown_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic [1:0]        wave_mode,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [CNT_W-1:0]  cpu_wdata,
  output logic [CNT_W-1:0]  cpu_rdata,
  input  logic              cmp_ie,
  input  logic              glob_ie,
  input  logic              ovf_ack,
  input  logic              cmp_ack,
  output logic [CNT_W-1:0]  count_o,
  output logic              at_top,
  output logic              at_bottom,
  output logic              cmp_match,
  output logic              ovf_flag,
  output logic              cmp_flag,
  output logic              cmp_irq
);

  logic             tick;
  logic             wr_cnt;
  logic             wr_cmp;
  logic             wr_flags;
  logic             ovf_evt;
  logic             cmp_set;
  logic [CNT_W-1:0] cmp_val;
  wave_mode_e       mode;

  assign tick     = tick_en && (clk_sel != '0);
  assign wr_cnt   = cpu_wr && (cpu_addr == ADDR_COUNT);
  assign wr_cmp   = cpu_wr && (cpu_addr == ADDR_CMP);
  assign wr_flags = cpu_wr && (cpu_addr == ADDR_FLAGS);
  assign mode     = wave_mode_e'(wave_mode);

  utmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_cnt    (wr_cnt),
    .wdata     (cpu_wdata),
    .mode      (mode),
    .match     (cmp_match),
    .count     (count_o),
    .ovf_evt   (ovf_evt),
    .at_top    (at_top),
    .at_bottom (at_bottom)
  );

  utmr_compare #(.CNT_W(CNT_W)) u_compare (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_cnt  (wr_cnt),
    .wr_cmp  (wr_cmp),
    .wdata   (cpu_wdata),
    .count   (count_o),
    .cmp_val (cmp_val),
    .match   (cmp_match),
    .cmp_set (cmp_set)
  );

  utmr_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovf_set    (ovf_evt),
    .cmp_set    (cmp_set),
    .wr_flags   (wr_flags),
    .wr_ovf_bit (cpu_wdata[FLAG_OVF_BIT]),
    .wr_cmp_bit (cpu_wdata[FLAG_CMP_BIT]),
    .ovf_ack    (ovf_ack),
    .cmp_ack    (cmp_ack),
    .cmp_ie     (cmp_ie),
    .glob_ie    (glob_ie),
    .ovf_flag   (ovf_flag),
    .cmp_flag   (cmp_flag),
    .cmp_irq    (cmp_irq)
  );

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      ADDR_COUNT: cpu_rdata = count_o;
      ADDR_CMP:   cpu_rdata = cmp_val;
      ADDR_FLAGS: begin
        cpu_rdata[FLAG_OVF_BIT] = ovf_flag;
        cpu_rdata[FLAG_CMP_BIT] = cmp_flag;
      end
      default:    cpu_rdata = '0;
    endcase
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_irq |-> (cmp_ie && glob_ie)) and (!cmp_flag |-> !cmp_irq)); // R12

endmodule

// File: tb/updown_timer_test.sv
module updown_timer_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, cpu_wr, cmp_ie, glob_ie, ovf_ack, cmp_ack;
  logic [2:0] clk_sel;
  logic [1:0] wave_mode, cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata, count_o;
  logic       at_top, at_bottom, cmp_match, ovf_flag, cmp_flag, cmp_irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  updown_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clk_sel(clk_sel),
    .wave_mode(wave_mode), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cmp_ie(cmp_ie),
    .glob_ie(glob_ie), .ovf_ack(ovf_ack), .cmp_ack(cmp_ack),
    .count_o(count_o), .at_top(at_top), .at_bottom(at_bottom),
    .cmp_match(cmp_match), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
    .cmp_irq(cmp_irq)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [7:0] cmpv, input logic [7:0] cntv);
    wave_mode = m;
    cpu_write(2'd1, cmpv);
    cpu_write(2'd0, cntv);
    cpu_write(2'd2, 8'h03);
  endtask

  task automatic t_reset();
    check("R1 count", count_o, 0);
    check("R1 ovf", ovf_flag, 0);
    check("R1 cmp flag", cmp_flag, 0);
    check("R1 irq", cmp_irq, 0);
    check("R1 bottom", at_bottom, 1);
    check("R1 top", at_top, 0);
    cpu_addr = 2'd1; #1;
    check("R1 compare reg", cpu_rdata, 0);
  endtask

  task automatic t_gating();
    wave_mode = 2'b00;
    cpu_write(2'd0, 8'd10);
    clk_sel = 3'b000;
    do_ticks(5);
    check("R2 sel zero holds", count_o, 10);
    cpu_write(2'd0, 8'd12);
    cpu_addr = 2'd0; #1;
    check("R2 cpu access when stopped", cpu_rdata, 12);
    clk_sel = 3'b001;
    repeat (5) @(negedge clk);
    check("R2 no enable holds", count_o, 12);
  endtask

  task automatic t_wrap();
    setup(2'b00, 8'd100, 8'd253);
    do_ticks(2);
    check("R3 count 255", count_o, 255);
    check("R3 ovf not yet", ovf_flag, 0);
    check("R8 top", at_top, 1);
    do_ticks(1);
    check("R3 wrap to 0", count_o, 0);
    check("R3 ovf set", ovf_flag, 1);
    check("R8 bottom", at_bottom, 1);
  endtask

  task automatic t_clear_bits();
    cpu_write(2'd2, 8'h00);
    check("R10 write zero no effect", ovf_flag, 1);
    cpu_addr = 2'd2; #1;
    check("R10 flag read bit0", cpu_rdata, 1);
    cpu_write(2'd2, 8'h01);
    check("R10 write one clears", ovf_flag, 0);
  endtask

  task automatic t_ovf_ack();
    setup(2'b00, 8'd100, 8'd255);
    do_ticks(1);
    check("R11 ovf before ack", ovf_flag, 1);
    @(negedge clk); ovf_ack = 1'b1;
    @(negedge clk); ovf_ack = 1'b0;
    check("R11 ovf ack clears", ovf_flag, 0);
  endtask

  task automatic t_ctc();
    setup(2'b10, 8'd5, 8'd3);
    do_ticks(2);
    check("R4 count at 5", count_o, 5);
    check("R9 match high", cmp_match, 1);
    check("R9 flag waits for tick", cmp_flag, 0);
    do_ticks(1);
    check("R4 clear on match", count_o, 0);
    check("R9 flag set", cmp_flag, 1);
    @(negedge clk); cmp_ack = 1'b1;
    @(negedge clk); cmp_ack = 1'b0;
    check("R11 cmp ack clears", cmp_flag, 0);
  endtask

  task automatic t_updown();
    setup(2'b01, 8'd100, 8'd254);
    do_ticks(2);
    check("R5 turn at top", count_o, 254);
    cpu_write(2'd0, 8'd1);
    cpu_write(2'd2, 8'h03);
    do_ticks(1);
    check("R5 descend to 0", count_o, 0);
    check("R5 no ovf yet", ovf_flag, 0);
    do_ticks(1);
    check("R5 turn at bottom", count_o, 1);
    check("R5 ovf at bottom", ovf_flag, 1);
  endtask

  task automatic t_topflag();
    setup(2'b11, 8'd100, 8'd253);
    do_ticks(1);
    check("R6 count 254", count_o, 254);
    check("R6 ovf not yet", ovf_flag, 0);
    do_ticks(1);
    check("R6 count 255", count_o, 255);
    check("R6 ovf with 255", ovf_flag, 1);
  endtask

  task automatic t_write_wins();
    wave_mode = 2'b00;
    @(negedge clk);
    tick_en = 1'b1; cpu_wr = 1'b1; cpu_addr = 2'd0; cpu_wdata = 8'd40;
    @(negedge clk);
    tick_en = 1'b0; cpu_wr = 1'b0;
    check("R7 write beats tick", count_o, 40);
    do_ticks(1);
    check("R7 counting resumes", count_o, 41);
  endtask

  task automatic t_irq();
    setup(2'b00, 8'd50, 8'd48);
    cmp_ie = 1'b0; glob_ie = 1'b1;
    do_ticks(3);
    check("R9 flag after tick at 50", cmp_flag, 1);
    check("R12 irq off without enable", cmp_irq, 0);
    cmp_ie = 1'b1; glob_ie = 1'b0; #1;
    check("R12 irq off without global", cmp_irq, 0);
    glob_ie = 1'b1; #1;
    check("R12 irq on", cmp_irq, 1);
    @(negedge clk); cmp_ack = 1'b1;
    @(negedge clk); cmp_ack = 1'b0;
    check("R12 irq drops with flag", cmp_irq, 0);
  endtask

  task automatic t_set_wins();
    setup(2'b00, 8'd70, 8'd69);
    do_ticks(1);
    @(negedge clk);
    tick_en = 1'b1; cpu_wr = 1'b1; cpu_addr = 2'd2; cpu_wdata = 8'h02;
    @(negedge clk);
    tick_en = 1'b0; cpu_wr = 1'b0;
    check("R10 set beats clear", cmp_flag, 1);
  endtask

  task automatic t_suppress();
    setup(2'b00, 8'd60, 8'd60);
    check("R13 match after write", cmp_match, 1);
    do_ticks(1);
    check("R13 count steps", count_o, 61);
    check("R13 flag suppressed", cmp_flag, 0);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; cpu_wr = 1'b0; cmp_ie = 1'b0; glob_ie = 1'b0;
    ovf_ack = 1'b0; cmp_ack = 1'b0; clk_sel = 3'b001; wave_mode = 2'b00;
    cpu_addr = 2'd0; cpu_wdata = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gating();
    t_wrap();
    t_clear_bits();
    t_ovf_ack();
    t_ctc();
    t_updown();
    t_topflag();
    t_write_wins();
    t_irq();
    t_set_wins();
    t_suppress();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule